// File: doc/BRIEF.md
# Live/Preview Transition Mixer

This block sits behind two effects channels, A and B, and produces two pixel streams. One is the programme (live) output. The other is the preview output, which shows the channel the operator is setting up. After reset channel A is live and channel B is on preview. The operator picks either a crossfade or a horizontal wipe and moves an 8-bit lever position. Position 0 shows only the live channel. Position 255 shows only the preview channel.

Once the lever has been pushed to its end, the next field boundary strobe exchanges the two channels' roles. The channel that was fading in stays on air without a visible step. Because the lever is still at the top, the block forces the effective position to zero after a swap. The lever drives the mix again only after it has gone back to 0. Every pixel carries a valid flag, and that flag travels with the pixel through a two-stage pipeline.

Top module: `av_transition_mixer`

## Requirements
- R1: While reset is asserted, and right after it is released, `out_valid`, `live_px` and `prev_px` are 0, `b_on_air` is 0 (channel A live), and the position hold is clear.
- R2: With `wipe_mode` = 0 (fade), `live_px` equals round(((255-k)*L + k*P)/255), where k is the effective position, L is the live channel pixel and P is the preview channel pixel. This value appears two clocks after the inputs are sampled.
- R3: With `wipe_mode` = 1 (wipe), `live_px` equals P when `col` < floor(k*LINE_W/256) and equals L otherwise, two clocks after the inputs are sampled.
- R4: `prev_px` always carries the channel that is not live, unblended. It has the same two-clock latency, and the channel is chosen by the role in force when the pixel was sampled.
- R5: `out_valid` repeats `in_valid` two clocks later.
- R6: A clock with `field_strobe` high and effective position 255 toggles `b_on_air` at that edge. A strobe at any other position has no effect.
- R7: After a swap, the effective position is 0 until `lever` reads 0. While this hold is active, a strobe cannot cause another swap.
- R8: In fade mode, effective position 0 gives exactly L and position 255 gives exactly P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the input pixels |
| pix_a | input | PIX_W | Channel A pixel |
| pix_b | input | PIX_W | Channel B pixel |
| col | input | COL_W | Column of the current pixel within its line |
| wipe_mode | input | 1 | 0 selects fade, 1 selects horizontal wipe |
| lever | input | POS_W | Transition position from the operator |
| field_strobe | input | 1 | One-clock pulse at each field boundary |
| out_valid | output | 1 | Qualifies the output pixels |
| live_px | output | PIX_W | Programme output pixel |
| prev_px | output | PIX_W | Preview output pixel |
| b_on_air | output | 1 | 1 when channel B is the live channel |

## Verification
Pixel results (`live_px`, `prev_px`) and `out_valid` are due on the second rising edge after the inputs are applied. The role flag `b_on_air` is due on the first rising edge after the strobe. The bench drives inputs on falling edges and reads pixel results on the second falling edge after each drive. It checks that `out_valid` is still low at the intermediate falling edge. It reads `b_on_air` at the falling edge that follows the strobe, and it computes the expected blend from the rounding formula independently of the design.

// File: rtl/av_transition_mixer.sv
module av_transition_mixer #(
  parameter int PIX_W  = 8,
  parameter int POS_W  = 8,
  parameter int COL_W  = 10,
  parameter int LINE_W = 720
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] pix_a,
  input  logic [PIX_W-1:0] pix_b,
  input  logic [COL_W-1:0] col,
  input  logic             wipe_mode,
  input  logic [POS_W-1:0] lever,
  input  logic             field_strobe,
  output logic             out_valid,
  output logic [PIX_W-1:0] live_px,
  output logic [PIX_W-1:0] prev_px,
  output logic             b_on_air
);

  localparam int FULL  = (1 << POS_W) - 1;
  localparam int ACC_W = PIX_W + POS_W + 1;
  localparam int THR_W = POS_W + COL_W;

  logic             b_live_q, hold_q;
  logic [POS_W-1:0] k_eff;
  logic [PIX_W-1:0] live_src, prev_src;
  logic [THR_W-1:0] thr_full;
  logic             wipe_pick;
  logic [ACC_W-1:0] acc;

  assign k_eff    = hold_q ? '0 : lever;
  assign live_src = b_live_q ? pix_b : pix_a;
  assign prev_src = b_live_q ? pix_a : pix_b;
  assign thr_full = THR_W'(k_eff) * THR_W'(LINE_W);
  assign wipe_pick = col < thr_full[THR_W-1:POS_W];
  assign acc = ACC_W'(POS_W'(FULL) - k_eff) * ACC_W'(live_src)
             + ACC_W'(k_eff) * ACC_W'(prev_src);
  assign b_on_air = b_live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_live_q <= 1'b0;
      hold_q   <= 1'b0;
    end else if (field_strobe && k_eff == POS_W'(FULL)) begin
      b_live_q <= ~b_live_q;
      hold_q   <= 1'b1;
    end else if (lever == '0) begin
      hold_q   <= 1'b0;
    end
  end

  logic             v1, mode1, pick1;
  logic [ACC_W-1:0] acc1;
  logic [PIX_W-1:0] live1, prev1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      mode1 <= 1'b0;
      pick1 <= 1'b0;
      acc1  <= '0;
      live1 <= '0;
      prev1 <= '0;
    end else begin
      v1    <= in_valid;
      mode1 <= wipe_mode;
      pick1 <= wipe_pick;
      acc1  <= acc;
      live1 <= live_src;
      prev1 <= prev_src;
    end
  end

  logic [ACC_W-1:0] faded;
  assign faded = (acc1 + ACC_W'(FULL / 2)) / ACC_W'(FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      live_px   <= '0;
      prev_px   <= '0;
    end else begin
      out_valid <= v1;
      live_px   <= mode1 ? (pick1 ? prev1 : live1) : faded[PIX_W-1:0];
      prev_px   <= prev1;
    end
  end

endmodule

// File: rtl/av_transition_mixer_chk.sv
module av_transition_mixer_chk #(
  parameter int PIX_W = 8,
  parameter int POS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] pix_a,
  input logic [PIX_W-1:0] pix_b,
  input logic             wipe_mode,
  input logic             field_strobe,
  input logic [POS_W-1:0] k_eff,
  input logic             out_valid,
  input logic [PIX_W-1:0] live_px,
  input logic [PIX_W-1:0] prev_px,
  input logic             b_on_air
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc == 2'd3 |-> out_valid == $past(in_valid, 2));

  assert_preview_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && out_valid) |->
      prev_px == ($past(b_on_air, 2) ? $past(pix_a, 2) : $past(pix_b, 2)));

  assert_swap_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && b_on_air != $past(b_on_air)) |->
      $past(field_strobe && k_eff == '1));

  assert_hold_after_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && b_on_air != $past(b_on_air)) |-> k_eff == '0);

  assert_fade_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && out_valid && $past(!wipe_mode && k_eff == '0, 2)) |->
      live_px == ($past(b_on_air, 2) ? $past(pix_b, 2) : $past(pix_a, 2)));
endmodule

bind av_transition_mixer av_transition_mixer_chk #(.PIX_W(PIX_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pix_a(pix_a), .pix_b(pix_b),
  .wipe_mode(wipe_mode), .field_strobe(field_strobe), .k_eff(k_eff),
  .out_valid(out_valid), .live_px(live_px), .prev_px(prev_px), .b_on_air(b_on_air)
);

// File: tb/tb_av_transition_mixer.sv
module tb_av_transition_mixer;
  localparam int LINE_W = 720;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, wipe_mode = 1'b0, field_strobe = 1'b0;
  logic [7:0] pix_a = '0, pix_b = '0, lever = '0;
  logic [9:0] col = '0;
  logic out_valid, b_on_air;
  logic [7:0] live_px, prev_px;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  av_transition_mixer #(.LINE_W(LINE_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pix_a(pix_a), .pix_b(pix_b),
    .col(col), .wipe_mode(wipe_mode), .lever(lever), .field_strobe(field_strobe),
    .out_valid(out_valid), .live_px(live_px), .prev_px(prev_px), .b_on_air(b_on_air));

  // {wipe_mode, k, a, b, col}
  localparam logic [34:0] VEC [12] = '{
    {1'b0, 8'd0,   8'd200, 8'd50,  10'd0},
    {1'b0, 8'd255, 8'd200, 8'd50,  10'd0},
    {1'b0, 8'd128, 8'd0,   8'd255, 10'd0},
    {1'b0, 8'd64,  8'd100, 8'd200, 10'd0},
    {1'b0, 8'd1,   8'd255, 8'd0,   10'd0},
    {1'b0, 8'd200, 8'd17,  8'd240, 10'd0},
    {1'b1, 8'd128, 8'd11,  8'd99,  10'd359},
    {1'b1, 8'd128, 8'd11,  8'd99,  10'd360},
    {1'b1, 8'd0,   8'd11,  8'd99,  10'd0},
    {1'b1, 8'd255, 8'd11,  8'd99,  10'd716},
    {1'b1, 8'd255, 8'd11,  8'd99,  10'd717},
    {1'b1, 8'd40,  8'd70,  8'd5,   10'd112}
  };

  function automatic logic [7:0] model(input logic m, input int k, input int l,
                                       input int p, input int c);
    if (m) return (c < (k * LINE_W) / 256) ? 8'(p) : 8'(l);
    return 8'((((255 - k) * l + k * p) + 127) / 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pixel(input logic m, input logic [7:0] k, input logic [7:0] a,
                       input logic [7:0] b, input logic [9:0] c);
    wipe_mode = m; lever = k; pix_a = a; pix_b = b; col = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 valid not early", out_valid, 0);
    @(negedge clk);
    chk("R5 valid delay", out_valid, 1);
  endtask

  task automatic strobe(input logic [7:0] k);
    lever = k; field_strobe = 1'b1;
    @(negedge clk);
    field_strobe = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 live_px", live_px, 0);
    chk("R1 prev_px", prev_px, 0);
    chk("R1 b_on_air", b_on_air, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {out_valid, b_on_air}, 0);

    foreach (VEC[i]) begin
      pixel(VEC[i][34], VEC[i][33:26], VEC[i][25:18], VEC[i][17:10], VEC[i][9:0]);
      chk(VEC[i][34] ? "R3 wipe" : "R2 fade", live_px,
          model(VEC[i][34], VEC[i][33:26], VEC[i][25:18], VEC[i][17:10], VEC[i][9:0]));
      chk("R4 preview", prev_px, VEC[i][17:10]);
    end

    pixel(1'b0, 8'd0, 8'd33, 8'd77, 10'd0);
    chk("R8 position 0", live_px, 33);
    pixel(1'b0, 8'd255, 8'd33, 8'd77, 10'd0);
    chk("R8 position 255", live_px, 77);

    strobe(8'd254);
    chk("R6 strobe below end ignored", b_on_air, 0);
    strobe(8'd255);
    chk("R6 swap at end", b_on_air, 1);

    pixel(1'b0, 8'd255, 8'd10, 8'd90, 10'd0);
    chk("R7 held position 0 after swap", live_px, 90);
    chk("R4 preview after swap", prev_px, 10);

    strobe(8'd255);
    chk("R7 no second swap during hold", b_on_air, 1);

    lever = 8'd0;
    @(negedge clk);
    pixel(1'b0, 8'd128, 8'd0, 8'd255, 10'd0);
    chk("R7 hold released", live_px, model(1'b0, 128, 255, 0, 0));

    strobe(8'd255);
    chk("R6 swap back", b_on_air, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule